// File: doc/BRIEF.md
# Secured OTP Command Controller for a Serial Flash Slave

This block sits behind the serial shift front end of a flash slave device and acts on command opcodes that arrive already deserialized. Each command frame is bounded by chip select going low and then high again. The controller keeps two pieces of state: whether the device is in secured one-time-programmable (OTP) mode, and whether the customer has permanently locked that region. From these it decides whether each command is accepted or dropped. It also steers accepted read and program requests either to the main array or to a separate 4K-bit (512-byte) OTP store.

A command takes effect on the rising edge of chip select, and only if a complete opcode byte arrived in that frame. An accepted access comes out as a one-cycle request that carries its kind, its target store and its address. The array side that carries out the request is outside this block. A command refused because of the current mode or lock state produces a one-cycle reject pulse and changes nothing. The security register read-out starts as soon as its opcode arrives. It stays valid until chip select rises, and it always shows the current bit values.

Top module: `sec_otp_ctrl`

## Requirements
- R1: After reset, otp_mode, acc_req, reject and sr_valid are 0, and the lock-down bit (security register bit 1) reads 0.
- R2: The enter opcode (default 0xB1) sets otp_mode and the exit opcode (default 0xC1) clears it. Each change is visible one clock after the clock edge that first samples chip select high, and neither command raises acc_req or reject.
- R3: A frame in which chip select rises without a complete opcode byte has no effect: no request, no reject and no change of mode or lock.
- R4: Outside OTP mode, read (0x03) and program (0x02) are accepted with acc_otp = 0 and acc_addr equal to the full addr_in. acc_kind is 0 for read and 1 for program.
- R5: In OTP mode, read and program (while unlocked) are accepted with acc_otp = 1 and acc_addr equal to addr_in modulo 512, with all bits above bit 8 at zero.
- R6: Outside OTP mode, the status-write opcode (0x01) is accepted as acc_kind = 2. The security-write opcode (0x2F) sets the lock-down bit if it is still clear, without raising acc_req or reject.
- R7: In OTP mode, the status-write and security-write opcodes are rejected, and mode and lock are left unchanged.
- R8: Once locked, the lock bit never clears. A further security-write is rejected. In OTP mode a program is rejected while a read is still accepted, and the exit opcode is still honoured.
- R9: The security-read opcode (0x2B) raises sr_valid one clock after the byte is sampled, and sr_valid stays high until the clock after chip select is seen high. sr_byte shows factory_lock at bit 0, the lock bit at bit 1, cp_mode at bit 4 and zero elsewhere, and it follows input changes while the frame is still open.
- R10: Opcodes that match no command cause neither acc_req nor reject.
- R11: acc_req and reject are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, bounds each frame |
| op_valid | input | 1 | A complete opcode byte is on op_code |
| op_code | input | OP_W | Deserialized opcode |
| addr_in | input | ADDR_W | Address for the frame, held until chip select rises |
| factory_lock | input | 1 | Factory lock strap |
| cp_mode | input | 1 | Continuous-program mode status |
| acc_req | output | 1 | Accepted access request pulse |
| acc_kind | output | 2 | 0 read, 1 program, 2 status write |
| acc_otp | output | 1 | 1 selects the OTP store, 0 the main array |
| acc_addr | output | ADDR_W | Steered address |
| reject | output | 1 | Command refused by mode or lock |
| otp_mode | output | 1 | Device is in secured OTP mode |
| sr_valid | output | 1 | Security register is being shifted out |
| sr_byte | output | SR_W | Current security register value |

## Verification
Every command result (acc_req, reject, acc_kind, acc_otp, acc_addr and the new otp_mode) is due one clock after the first edge that samples chip select high. The bench raises chip select on a falling edge and samples on the following falling edge, so exactly one register stage lies between stimulus and check. sr_valid is due one clock after the opcode edge, and it drops one clock after chip select is seen high. sr_byte is combinational, so the bench checks it shortly after changing the strap inputs. A reference model in the bench tracks mode and lock. It runs every opcode in both modes and both lock states and compares each pulse in that single sampled cycle.

// File: rtl/sec_otp_pkg.sv
package sec_otp_pkg;
   typedef enum logic [1:0] {
      KIND_READ = 2'd0,
      KIND_PROG = 2'd1,
      KIND_STAT = 2'd2
   } acc_kind_e;

   localparam int SCUR_FACTORY_BIT = 0;
   localparam int SCUR_LOCK_BIT    = 1;
   localparam int SCUR_CP_BIT      = 4;
endpackage

// File: rtl/sec_frame_trk.sv
module sec_frame_trk #(
   parameter int OP_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            op_valid,
   input  logic [OP_W-1:0] op_code,
   output logic            commit,
   output logic            op_first,
   output logic [OP_W-1:0] cmd_op
);
   logic cs_q;
   logic have_op;

   if (OP_W < 1) begin : g_chk_w
      $error("OP_W must be positive");
   end

   assign op_first = op_valid && !cs_n && !have_op;
   assign commit   = cs_n && !cs_q && have_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q    <= 1'b1;
         have_op <= 1'b0;
         cmd_op  <= '0;
      end else begin
         cs_q <= cs_n;
         if (cs_n) begin
            have_op <= 1'b0;
         end else if (op_first) begin
            have_op <= 1'b1;
            cmd_op  <= op_code;
         end
      end
   end

   a_r3_commit_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> $past(!cs_n));
endmodule

// File: rtl/sec_cmd_gate.sv
module sec_cmd_gate
   import sec_otp_pkg::*;
#(
   parameter int             OP_W     = 8,
   parameter logic [OP_W-1:0] OP_ENTER = 8'hB1,
   parameter logic [OP_W-1:0] OP_EXIT  = 8'hC1,
   parameter logic [OP_W-1:0] OP_READ  = 8'h03,
   parameter logic [OP_W-1:0] OP_PROG  = 8'h02,
   parameter logic [OP_W-1:0] OP_STATW = 8'h01,
   parameter logic [OP_W-1:0] OP_SECW  = 8'h2F,
   parameter logic [OP_W-1:0] OP_SECR  = 8'h2B
) (
   input  logic            commit,
   input  logic [OP_W-1:0] cmd_op,
   input  logic            op_first,
   input  logic [OP_W-1:0] op_code,
   input  logic            in_otp,
   input  logic            locked,
   output logic            accept,
   output logic            refuse,
   output acc_kind_e       kind,
   output logic            set_mode,
   output logic            clr_mode,
   output logic            set_lock,
   output logic            rd_start
);
   if (OP_ENTER == OP_EXIT || OP_READ == OP_PROG || OP_STATW == OP_SECW) begin : g_chk_ops
      $error("opcode parameters must be distinct");
   end

   assign rd_start = op_first && (op_code == OP_SECR);

   always_comb begin
      accept   = 1'b0;
      refuse   = 1'b0;
      kind     = KIND_READ;
      set_mode = 1'b0;
      clr_mode = 1'b0;
      set_lock = 1'b0;
      if (commit) begin
         if (cmd_op == OP_ENTER) begin
            set_mode = 1'b1;
         end else if (cmd_op == OP_EXIT) begin
            clr_mode = 1'b1;
         end else if (cmd_op == OP_READ) begin
            accept = 1'b1;
         end else if (cmd_op == OP_PROG) begin
            kind   = KIND_PROG;
            refuse = in_otp && locked;
            accept = !refuse;
         end else if (cmd_op == OP_STATW) begin
            kind   = KIND_STAT;
            refuse = in_otp;
            accept = !in_otp;
         end else if (cmd_op == OP_SECW) begin
            refuse   = in_otp || locked;
            set_lock = !refuse;
         end
      end
   end
endmodule

// File: rtl/sec_mode_state.sv
module sec_mode_state
   import sec_otp_pkg::*;
#(
   parameter int SR_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            set_mode,
   input  logic            clr_mode,
   input  logic            set_lock,
   input  logic            rd_start,
   input  logic            factory_lock,
   input  logic            cp_mode,
   output logic            otp_mode,
   output logic            locked,
   output logic            sr_valid,
   output logic [SR_W-1:0] sr_byte
);
   if (SR_W <= SCUR_CP_BIT) begin : g_chk_sr
      $error("SR_W too narrow for the status bits");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         otp_mode <= 1'b0;
         locked   <= 1'b0;
         sr_valid <= 1'b0;
      end else begin
         if (set_mode)      otp_mode <= 1'b1;
         else if (clr_mode) otp_mode <= 1'b0;
         if (set_lock)      locked   <= 1'b1;
         if (cs_n)          sr_valid <= 1'b0;
         else if (rd_start) sr_valid <= 1'b1;
      end
   end

   always_comb begin
      sr_byte                   = '0;
      sr_byte[SCUR_FACTORY_BIT] = factory_lock;
      sr_byte[SCUR_LOCK_BIT]    = locked;
      sr_byte[SCUR_CP_BIT]      = cp_mode;
   end

   a_r2_mode_moves_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(otp_mode) |-> $past(set_mode || clr_mode));
   a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> locked);
   a_r9_read_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      sr_valid |-> $past(!cs_n));
endmodule

// File: rtl/sec_otp_ctrl.sv
module sec_otp_ctrl
   import sec_otp_pkg::*;
#(
   parameter int             OP_W      = 8,
   parameter int             ADDR_W    = 24,
   parameter int             OTP_BYTES = 512,
   parameter int             SR_W      = 8,
   parameter logic [OP_W-1:0] OP_ENTER  = 8'hB1,
   parameter logic [OP_W-1:0] OP_EXIT   = 8'hC1,
   parameter logic [OP_W-1:0] OP_READ   = 8'h03,
   parameter logic [OP_W-1:0] OP_PROG   = 8'h02,
   parameter logic [OP_W-1:0] OP_STATW  = 8'h01,
   parameter logic [OP_W-1:0] OP_SECW   = 8'h2F,
   parameter logic [OP_W-1:0] OP_SECR   = 8'h2B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              op_valid,
   input  logic [OP_W-1:0]   op_code,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              factory_lock,
   input  logic              cp_mode,
   output logic              acc_req,
   output logic [1:0]        acc_kind,
   output logic              acc_otp,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              reject,
   output logic              otp_mode,
   output logic              sr_valid,
   output logic [SR_W-1:0]   sr_byte
);
   localparam int OTP_AW = $clog2(OTP_BYTES);

   if ((1 << OTP_AW) != OTP_BYTES || OTP_AW > ADDR_W) begin : g_chk_otp
      $error("OTP_BYTES must be a power of two that fits ADDR_W");
   end

   logic            commit, op_first, accept, refuse;
   logic            set_mode, clr_mode, set_lock, rd_start, locked;
   logic [OP_W-1:0] cmd_op;
   acc_kind_e       kind;
   logic [ADDR_W-1:0] steer_addr;

   sec_frame_trk #(.OP_W(OP_W)) frame_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_valid(op_valid),
      .op_code(op_code), .commit(commit), .op_first(op_first), .cmd_op(cmd_op)
   );

   sec_cmd_gate #(
      .OP_W(OP_W), .OP_ENTER(OP_ENTER), .OP_EXIT(OP_EXIT), .OP_READ(OP_READ),
      .OP_PROG(OP_PROG), .OP_STATW(OP_STATW), .OP_SECW(OP_SECW), .OP_SECR(OP_SECR)
   ) gate_i (
      .commit(commit), .cmd_op(cmd_op), .op_first(op_first), .op_code(op_code),
      .in_otp(otp_mode), .locked(locked), .accept(accept), .refuse(refuse),
      .kind(kind), .set_mode(set_mode), .clr_mode(clr_mode),
      .set_lock(set_lock), .rd_start(rd_start)
   );

   sec_mode_state #(.SR_W(SR_W)) state_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .set_mode(set_mode),
      .clr_mode(clr_mode), .set_lock(set_lock), .rd_start(rd_start),
      .factory_lock(factory_lock), .cp_mode(cp_mode), .otp_mode(otp_mode),
      .locked(locked), .sr_valid(sr_valid), .sr_byte(sr_byte)
   );

   if (OTP_AW < ADDR_W) begin : g_mask
      assign steer_addr = otp_mode ? {{(ADDR_W-OTP_AW){1'b0}}, addr_in[OTP_AW-1:0]}
                                   : addr_in;
      a_r5_otp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_req && acc_otp) |-> (acc_addr[ADDR_W-1:OTP_AW] == '0));
   end else begin : g_full
      assign steer_addr = addr_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_req  <= 1'b0;
         acc_kind <= KIND_READ;
         acc_otp  <= 1'b0;
         acc_addr <= '0;
         reject   <= 1'b0;
      end else begin
         acc_req <= accept;
         reject  <= refuse;
         if (accept) begin
            acc_kind <= kind;
            acc_otp  <= otp_mode && (kind != KIND_STAT);
            acc_addr <= steer_addr;
         end
      end
   end

   a_r11_req_xor_reject: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_req && reject));
   a_r7_reject_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> ($stable(otp_mode) && $stable(locked)));
   a_r8_no_locked_otp_prog: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && acc_otp && acc_kind == KIND_PROG) |-> !locked);
endmodule

// File: tb/sec_otp_ctrl_tb_top.sv
module sec_otp_ctrl_tb_top;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          op_valid = 1'b0;
   logic [7:0]    op_code = '0;
   logic [AW-1:0] addr_in = '0;
   logic          factory_lock = 1'b1;
   logic          cp_mode = 1'b0;
   logic          acc_req, acc_otp, reject, otp_mode, sr_valid;
   logic [1:0]    acc_kind;
   logic [AW-1:0] acc_addr;
   logic [7:0]    sr_byte;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit m_mode = 1'b0;
   bit m_lock = 1'b0;

   always #2 clk = ~clk;

   sec_otp_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .op_valid(op_valid),
      .op_code(op_code), .addr_in(addr_in), .factory_lock(factory_lock),
      .cp_mode(cp_mode), .acc_req(acc_req), .acc_kind(acc_kind),
      .acc_otp(acc_otp), .acc_addr(acc_addr), .reject(reject),
      .otp_mode(otp_mode), .sr_valid(sr_valid), .sr_byte(sr_byte)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_sr();
      return {3'b000, cp_mode, 2'b00, m_lock, factory_lock};
   endfunction

   // one frame; samples the result cycle
   task automatic frame(input logic [7:0] op, input logic [AW-1:0] a, input bit with_op);
      @(negedge clk) cs_n = 1'b0;
      if (with_op) begin
         @(negedge clk) begin op_valid = 1'b1; op_code = op; addr_in = a; end
         @(negedge clk) op_valid = 1'b0;
      end
      @(negedge clk) cs_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_cmd(input logic [7:0] op, input logic [AW-1:0] a, input string req);
      bit e_req = 0, e_rej = 0;
      int e_kind = 0;
      bit e_otp = 0;
      logic [AW-1:0] e_addr = a;
      case (op)
         8'hB1: m_mode = 1'b1;
         8'hC1: m_mode = 1'b0;
         8'h03: begin e_req = 1; e_kind = 0; end
         8'h02: begin e_rej = m_mode && m_lock; e_req = !e_rej; e_kind = 1; end
         8'h01: begin e_rej = m_mode; e_req = !m_mode; e_kind = 2; end
         8'h2F: begin e_rej = m_mode || m_lock; if (!e_rej) m_lock = 1'b1; end
         default: ;
      endcase
      if (e_kind != 2) begin
         e_otp = m_mode;
         if (m_mode) e_addr = a & 24'h0001FF;
      end
      frame(op, a, 1'b1);
      chk(req, $sformatf("acc_req op %0h", op), acc_req, e_req);
      chk(req, $sformatf("reject op %0h", op), reject, e_rej);
      chk("R2", "otp_mode", otp_mode, m_mode);
      if (e_req) begin
         chk(req, "acc_kind", acc_kind, e_kind);
         chk(req, "acc_otp", acc_otp, e_otp);
         if (e_kind != 2) chk(req, "acc_addr", acc_addr, e_addr);
      end
      @(negedge clk);
      chk("R11", "pulse width", acc_req | reject, 0);
   endtask

   task automatic sec_read(input string req);
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) begin op_valid = 1'b1; op_code = 8'h2B; end
      @(negedge clk) op_valid = 1'b0;
      chk("R9", "sr_valid rise", sr_valid, 1);
      chk(req, "sr_byte", sr_byte, exp_sr());
      cp_mode = ~cp_mode; factory_lock = ~factory_lock;
      #1 chk("R9", "sr_byte follows", sr_byte, exp_sr());
      @(negedge clk) chk("R9", "sr_valid held", sr_valid, 1);
      cs_n = 1'b1;
      @(negedge clk) chk("R9", "sr_valid drop", sr_valid, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] ops [8] = '{8'h03, 8'h02, 8'h01, 8'h2B, 8'h5A, 8'hB1, 8'hC1, 8'h2F};
      repeat (3) @(negedge clk);
      chk("R1", "otp_mode", otp_mode, 0);
      chk("R1", "acc_req", acc_req, 0);
      chk("R1", "reject", reject, 0);
      chk("R1", "sr_valid", sr_valid, 0);
      rst_n = 1'b1;
      sec_read("R1");
      // aborted frames
      frame(8'h00, '0, 1'b0);
      chk("R3", "abort acc_req", acc_req, 0);
      chk("R3", "abort reject", reject, 0);
      chk("R3", "abort mode", otp_mode, 0);
      run_cmd(8'hB1, '0, "R2");
      frame(8'h00, '0, 1'b0);
      chk("R3", "abort keeps mode", otp_mode, 1);
      run_cmd(8'hC1, '0, "R2");
      // sweep: pass x mode x opcode, model tracks lock
      for (int p = 0; p < 2; p++) begin
         for (int m = 1; m >= 0; m--) begin
            for (int i = 0; i < 8; i++) begin
               logic [AW-1:0] a;
               string r;
               a = 24'hA50000 ^ AW'(i * 24'h1357) ^ AW'(m * 24'h3C3) ^ AW'(p * 24'h800);
               run_cmd(m ? 8'hB1 : 8'hC1, '0, "R2");
               if (i >= 4 && i <= 4) r = "R10";
               else if (ops[i] == 8'h2F) r = m ? "R7" : (m_lock ? "R8" : "R6");
               else if (ops[i] == 8'h01) r = m ? "R7" : "R6";
               else if (ops[i] == 8'h02 && m_lock && m) r = "R8";
               else r = m ? "R5" : "R4";
               run_cmd(ops[i], a, r);
            end
         end
         sec_read(p == 0 ? "R6" : "R8");
      end
      run_cmd(8'hB1, '0, "R8");
      run_cmd(8'h03, 24'hFFFFFF, "R8");
      run_cmd(8'h02, 24'h000010, "R8");
      run_cmd(8'hC1, '0, "R8");
      sec_read("R8");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule